// File: doc/BRIEF.md
# ADC Continuous Conversion Sequencer

This block controls the conversions of a sampling converter. Software writes two small control registers. These select the analog input, the buffer mode and the reference. They also start a conversion and say whether conversions continue. The sequencer counts the conversion time and captures a 13-bit signed sample from a digital input at the end of each conversion. It stores that sample in a high/low register pair and pulses an interrupt request for one cycle.

The first conversion after a start is long. It takes extra cycles when the internal reference has to settle first. When it ends, the start bit drops back to 0. In continuous mode the sequencer then delivers a fresh sample on a short fixed period until software clears the continuous bit. In single mode it returns to idle after the first sample.

Top module: `adc_seq`

## Requirements
- R1: After the synchronous active-high reset, all four readable registers read 0x00, `irq` is 0, `ref_sel` is 0 and `ref_pin` is 0.
- R2: A write of 1 to the start bit while idle, with power-up not needed, produces the first sample 5129 cycles after the write edge. `samp_in` is captured on that completion edge, and the result registers and `irq` change on it.
- R3: The first conversion takes 40 more cycles (5169) when the reference selection that results from the start write is nonzero and the reference is not warm. The reference becomes warm at such a start. Any register write that changes the two-bit `ref_sel` clears the warm state. A start with `ref_sel` at 0 leaves the reference cold.
- R4: Control register 0 bit 7 (start) reads 1 only while the first conversion is running. It reads 0 after the first completion, including through every later result in continuous mode.
- R5: With the continuous bit (control 0 bit 6) at 1, results follow the first one every 256 cycles. Each result pulses `irq` high for exactly one cycle.
- R6: The 13-bit sample is packed with bits 12:5 in data-high (address 2) and bits 4:0 in data-low bits 7:3 (address 3). Data-low bits 2:0 read 0. Both registers change on the same edge, and only on a completion edge.
- R7: With the continuous bit at 0, exactly one conversion takes place and the sequencer returns to idle.
- R8: Clearing the continuous bit while samples are streaming stops the sequencer. Writing 0 to the start bit during the first conversion aborts it. After either one, no further `irq` occurs and the data registers keep their values.
- R9: `ref_pin` is 1 only when the reference-output bit (control 0 bit 5) is 1 and `ref_sel` is nonzero.
- R10: Writing 1 to the start bit while a conversion is running does not restart or shift its timing.
- R11: Register map. Address 0 is {start, cont, ref_out, ref_lo, insel[3:0]}. Address 1 is {ref_hi, 0000, bufmode[2:0]}. `ref_sel` = {ref_hi, ref_lo}. `ana_sel` and `buf_mode` follow insel and bufmode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control 0, 1 control 1) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| samp_in | input | 13 | Digital sample from the converter front end |
| ana_sel | output | 4 | Analog input selection |
| buf_mode | output | 3 | Input buffer mode |
| ref_sel | output | 2 | Reference selection, 0 means internal reference off |
| ref_pin | output | 1 | Drive internal reference onto pin |
| irq | output | 1 | Conversion-complete request, one-cycle pulse |

## Verification
The hardest situation to reach is the warm-reference shortcut. The reference must first be powered by one start with a nonzero selection. A second start must then follow with the same selection and no write that changes it in between. After that, a write that alters only the low reference bit must bring the 40-cycle penalty back. The stimulus chains exactly these three starts and measures each latency from the write edge. A behavioural model, compared on every clock, also covers the stop and abort paths during streaming and during the first conversion.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int FIRST_CYC  = 5129,
  parameter int PWRUP_CYC  = 40,
  parameter int PERIOD_CYC = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [12:0] samp_in,
  output logic [3:0]  ana_sel,
  output logic [2:0]  buf_mode,
  output logic [1:0]  ref_sel,
  output logic        ref_pin,
  output logic        irq
);
  localparam int CW = $clog2(FIRST_CYC + PWRUP_CYC + PERIOD_CYC + 1);
  localparam logic [CW-1:0] FIRST_LD = CW'(FIRST_CYC - 1);
  localparam logic [CW-1:0] PWR_LD   = CW'(FIRST_CYC + PWRUP_CYC - 1);
  localparam logic [CW-1:0] PER_LD   = CW'(PERIOD_CYC - 1);

  logic busy, first, cont, ref_out_b, ref_lo, ref_hi, warm;
  logic [3:0] insel;
  logic [2:0] bmode;
  logic [CW-1:0] cnt;
  logic [12:0] res;
  logic [1:0] ref_nxt;

  wire wr0 = wr_en && (wr_addr == 2'd0);
  wire wr1 = wr_en && (wr_addr == 2'd1);

  assign ref_nxt  = {wr1 ? wr_data[7] : ref_hi, wr0 ? wr_data[4] : ref_lo};
  assign ref_sel  = {ref_hi, ref_lo};
  assign ref_pin  = ref_out_b && (ref_sel != 2'b00);
  assign ana_sel  = insel;
  assign buf_mode = bmode;

  wire go       = wr0 && wr_data[7] && !busy;
  wire need_pwr = (ref_nxt != 2'b00) && !(warm && ref_nxt == ref_sel);
  wire abort    = busy && first && wr0 && !wr_data[7];
  wire stop     = busy && !first && !cont;
  wire done     = busy && !abort && !stop && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; first <= 1'b0; cont <= 1'b0; ref_out_b <= 1'b0;
      ref_lo <= 1'b0; ref_hi <= 1'b0; warm <= 1'b0; insel <= '0;
      bmode <= '0; cnt <= '0; res <= '0; irq <= 1'b0;
    end else begin
      if (wr0) {cont, ref_out_b, ref_lo, insel} <= wr_data[6:0];
      if (wr1) begin
        ref_hi <= wr_data[7];
        bmode  <= wr_data[2:0];
      end
      irq <= done;
      if (go) warm <= (ref_nxt != 2'b00);
      else if (ref_nxt != ref_sel) warm <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        first <= 1'b1;
        cnt   <= need_pwr ? PWR_LD : FIRST_LD;
      end else if (abort || stop) begin
        busy  <= 1'b0;
        first <= 1'b0;
      end else if (done) begin
        res   <= samp_in;
        first <= 1'b0;
        busy  <= cont;
        cnt   <= PER_LD;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {first, cont, ref_out_b, ref_lo, insel};
      2'd1:    rd_data = {ref_hi, 4'b0000, bmode};
      2'd2:    rd_data = res[12:5];
      default: rd_data = {res[4:0], 3'b000};
    endcase
  end

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (rst) !irq |-> $stable(res));
  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (rst) (busy && !first) |=> !first);
  // R9
  ref_pin_chk: assert property (@(posedge clk) disable iff (rst) ref_pin |-> (ref_sel != 2'b00));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |=> !irq);
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FIRST = 5129, PWR = 40, PER = 256;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [12:0] samp_in = 0;
  logic [3:0] ana_sel;
  logic [2:0] buf_mode;
  logic [1:0] ref_sel;
  logic ref_pin, irq;

  adc_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .samp_in(samp_in), .ana_sel(ana_sel),
    .buf_mode(buf_mode), .ref_sel(ref_sel), .ref_pin(ref_pin), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, t_wr = 0, irq_cnt = 0, last_irq = 0;
  bit running = 0, hold = 0;
  logic [12:0] hold_val = 0;
  int unsigned seed = 32'h1234_5678;

  bit m_busy, m_first, m_cont, m_refout, m_reflo, m_refhi, m_warm, m_irq;
  bit [3:0] m_insel;
  bit [2:0] m_bm;
  bit [12:0] m_res;
  int m_rem;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (hold) samp_in = hold_val;
    else begin
      seed = seed * 1103515245 + 12345;
      samp_in = seed[20:8];
    end
  end

  // behavioural model
  always @(posedge clk) begin
    bit w0, w1, go, abort, stop, pw;
    bit [1:0] oref, nref;
    if (rst) begin
      m_busy = 0; m_first = 0; m_cont = 0; m_refout = 0; m_reflo = 0; m_refhi = 0;
      m_warm = 0; m_irq = 0; m_insel = 0; m_bm = 0; m_res = 0; m_rem = 0;
    end else begin
      w0 = wr_en && wr_addr == 0;
      w1 = wr_en && wr_addr == 1;
      oref = {m_refhi, m_reflo};
      nref = {w1 ? wr_data[7] : m_refhi, w0 ? wr_data[4] : m_reflo};
      go = w0 && wr_data[7] && !m_busy;
      abort = m_busy && m_first && w0 && !wr_data[7];
      stop = m_busy && !m_first && !m_cont;
      m_irq = 0;
      if (go) begin
        pw = (nref != 0) && !(m_warm && nref == oref);
        m_rem = FIRST + (pw ? PWR : 0);
        m_busy = 1; m_first = 1;
      end else if (abort || stop) begin
        m_busy = 0; m_first = 0;
      end else if (m_busy) begin
        if (m_rem == 1) begin
          m_res = samp_in; m_irq = 1; m_first = 0; m_busy = m_cont; m_rem = PER;
        end else m_rem--;
      end
      if (go) m_warm = (nref != 0);
      else if (nref != oref) m_warm = 0;
      if (w0) {m_cont, m_refout, m_reflo, m_insel} = wr_data[6:0];
      if (w1) begin m_refhi = wr_data[7]; m_bm = wr_data[2:0]; end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk("R5 irq", irq, m_irq);
      chk("R11 ana_sel", ana_sel, m_insel);
      chk("R11 buf_mode", buf_mode, m_bm);
      chk("R3 ref_sel", ref_sel, {m_refhi, m_reflo});
      chk("R9 ref_pin", ref_pin, m_refout && {m_refhi, m_reflo} != 0);
      case (rd_addr)
        2'd0: chk("R4 ctrl0", rd_data, {m_first, m_cont, m_refout, m_reflo, m_insel});
        2'd1: chk("R11 ctrl1", rd_data, {m_refhi, 4'b0000, m_bm});
        2'd2: chk("R6 data_hi", rd_data, m_res[12:5]);
        default: chk("R6 data_lo", rd_data, {m_res[4:0], 3'b000});
      endcase
      if (irq) begin irq_cnt++; last_irq = cyc; end
      rd_addr = rd_addr + 1;
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    t_wr = cyc; wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int lim, output int lat);
    int c0 = irq_cnt;
    lat = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk); #2;
      if (irq_cnt > c0) begin lat = last_irq - t_wr; break; end
    end
  endtask

  task automatic rd(input bit [1:0] a, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #2;
      if (rd_addr == a) begin d = rd_data; break; end
    end
  endtask

  task automatic conv_sample(input logic [12:0] v, input logic [7:0] ehi, input logic [7:0] elo);
    int lat;
    logic [7:0] d;
    hold = 1; hold_val = v;
    wr(0, 8'h80);
    wait_irq(FIRST + 20, lat);
    rd(2, d); chk("R6 pack hi", d, ehi);
    rd(3, d); chk("R6 pack lo", d, elo);
    hold = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, c0, t0, prev;
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk); #1; rst = 0;
    @(negedge clk); #2;
    chk("R1 irq", irq, 0); chk("R1 ref_sel", ref_sel, 0); chk("R1 ref_pin", ref_pin, 0);
    running = 1;
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1 reg", d, 0); end

    // single conversion, reference off
    c0 = irq_cnt;
    wr(0, 8'h85);
    wait_irq(FIRST + 100, lat); chk("R2 first latency", lat, FIRST);
    idle(700); chk("R7 single count", irq_cnt - c0, 1);

    // power-up and warm reference
    wr(1, 8'h80);
    wr(0, 8'h80); wait_irq(FIRST + 100, lat); chk("R3 cold latency", lat, FIRST + PWR);
    wr(0, 8'h80); wait_irq(FIRST + 100, lat); chk("R3 warm latency", lat, FIRST);
    wr(0, 8'h10);
    wr(0, 8'h90); wait_irq(FIRST + 100, lat); chk("R3 rewarm latency", lat, FIRST + PWR);

    // reference pin gating
    wr(0, 8'h30); chk("R9 pin on", ref_pin, 1);
    wr(1, 8'h00); chk("R9 pin lo only", ref_pin, 1);
    wr(0, 8'h20); chk("R9 pin ref off", ref_pin, 0);

    // continuous stream
    c0 = irq_cnt;
    wr(0, 8'hC3); wait_irq(FIRST + 100, lat); chk("R5 first latency", lat, FIRST);
    for (int k = 0; k < 5; k++) begin
      prev = last_irq;
      wait_irq(PER + 20, lat);
      chk("R5 period", last_irq - prev, PER);
    end
    rd(0, d); chk("R4 start low in stream", d[7], 0);
    wr(0, 8'h03); c0 = irq_cnt;
    idle(700); chk("R8 stop stream", irq_cnt - c0, 0);

    // abort during first conversion
    wr(0, 8'h80); idle(1000);
    rd(0, d); chk("R4 start high in first", d[7], 1);
    rd(2, d);
    wr(0, 8'h00); c0 = irq_cnt;
    idle(FIRST + 200); chk("R8 abort", irq_cnt - c0, 0);
    begin logic [7:0] d2; rd(2, d2); chk("R8 data kept", d2, d); end

    // restart while busy
    wr(0, 8'h80); t0 = t_wr; idle(2000);
    wr(0, 8'h80);
    wait_irq(FIRST, lat); chk("R10 restart ignored", last_irq - t0, FIRST);

    // packing
    conv_sample(13'h1FFF, 8'hFF, 8'hF8);
    conv_sample(13'h1000, 8'h80, 8'h00);
    conv_sample(13'h0ABC, 8'h55, 8'hE0);

    // control 1 readback
    wr(1, 8'hFD);
    rd(1, d); chk("R11 ctrl1 readback", d, 8'h85);
    chk("R11 buf_mode out", buf_mode, 5);
    idle(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule